// File: doc/BRIEF.md
# Byte-Paced I2C Master Controller

This block is an I2C bus master driven by software through four byte-wide registers. Software loads a byte and then issues a command. The command is a START, the release of the interrupt-pending flag, or a STOP. The controller then moves exactly one byte across SCL and SDA, plus the ninth acknowledge clock. When the byte is done it raises interrupt-pending again and parks the bus with SCL low until software answers. Each byte therefore needs one software handshake. The SCL rate is chosen by a coarse prescaler and a 4-bit divisor.

The first byte after a START is always sent, and it is the slave address with the read/write bit in bit 0. The bytes after it are sent or received according to the mode held in the status register. In receive mode the controller drives the acknowledge bit from an acknowledge-enable control bit. Software clears that bit before the last byte so that the slave sees a NACK. A START issued while a transfer is parked produces a repeated START without an intermediate STOP.

Register addresses: 0 control, 1 status, 2 data shift, 3 address (plain storage). Control: [7] ACK enable, [6] slow prescale, [5] interrupt enable, [4] pending, [3:0] divisor. Status: [7:6] mode (10 master receive, 11 master transmit), [5] command on write / busy on read, [4] output enable, [0] received ACK.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset all four registers read 0x00, SCL and SDA are both high (released) and the interrupt output is low.
- R2: The SCL period in clock cycles is P*(D+1), where D is control[3:0] and P is 512 when control[6] is 1 and 16 when it is 0.
- R3: Writing the status register with bits 7, 5 and 4 all set while the bus is idle makes SDA fall while SCL is high, then sends the data register MSB first as the address byte. Status bit 5 reads 1 from that write until the STOP has completed.
- R4: Control bit 4 (pending) is set by the controller at the end of every nine-clock byte. Software writing it as 0 clears it, and writing it as 1 never sets it. The interrupt output equals pending AND control bit 5.
- R5: While pending is set, SCL stays low and no further bus activity starts.
- R6: In master-transmit mode (status[7:6]=11), clearing pending with no command outstanding shifts the data register out MSB first, and SDA changes only while SCL is low.
- R7: Status bit 0 holds the SDA level sampled on the ninth SCL pulse of the last byte: 0 means the slave acknowledged, 1 means it did not.
- R8: In master-receive mode (status[7:6]=10), a byte is shifted in MSB first and is readable in the data register once pending rises. On the ninth clock SDA is driven low when control[7] is 1 and left high when it is 0.
- R9: A status write with bits 7, 5 and 4 set while a transfer is parked, followed by clearing pending, makes SCL rise with SDA high and then SDA fall while SCL is high. No STOP comes before it. The data register is then sent as the new address byte.
- R10: A status write with bit 5 as 0 and bit 4 as 1 during a transfer, followed by clearing pending, makes SDA rise while SCL is high. Both lines are then left high, status bit 5 reads 0, and pending stays 0.
- R11: The register at address 3 stores and returns any byte written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on bus_addr) |
| irq | output | 1 | Interrupt request |
| scl_o | output | 1 | SCL level, 1 = released |
| sda_o | output | 1 | SDA level, 1 = released |
| sda_i | input | 1 | Sampled SDA line |

## Verification
Some rules are checked on every cycle. SDA may not change while SCL is high inside a byte. SDA may fall only with SCL high during a START, and may rise only with SCL high during a STOP. Pending may rise only on a byte completion. SCL stays low whenever pending is set. The bit-timing ticks never come back to back. Other behaviour is only visible through the directed scenarios against a modelled slave. These are the measured SCL period for both prescale choices, the bytes that reach the slave, the received-ACK bit, the ACK or NACK the master drives while receiving, the repeated START without a STOP before it, and the register values after each step.

// File: rtl/i2cm_pkg.sv
// Shared constants and types for the byte-paced I2C master.
// Assumes the fixed register map described in the brief.
package i2cm_pkg;
    localparam int DIV_W     = 4;
    localparam int BYTE_W    = 8;
    localparam int PHASES    = 4;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_SADR = 2'd3;

    localparam logic [1:0] MODE_MRX = 2'b10;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_START,
        ENG_BIT,
        ENG_HOLD,
        ENG_STOP
    } eng_state_t;
endpackage

// File: rtl/i2cm_tick.sv
// Phase-tick generator: one tick per quarter SCL period.
// Assumes PRE_LO and PRE_HI are multiples of 4 and PRE_LO >= 8,
// so a tick never occurs on two consecutive cycles.
module i2cm_tick #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_hi,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int Q_LO = PRE_LO / i2cm_pkg::PHASES;
    localparam int Q_HI = PRE_HI / i2cm_pkg::PHASES;
    localparam int MAXL = Q_HI * (1 << DIV_W);
    localparam int CW   = $clog2(MAXL + 1);

    logic [CW-1:0] lim;
    logic [CW-1:0] cnt;

    // Phase length in clocks from prescale choice and divisor.
    always_comb lim = (pre_hi ? CW'(Q_HI) : CW'(Q_LO)) * (CW'(div) + CW'(1));

    assign tick = run && (cnt == lim - CW'(1));

    // Count clocks within a phase, restarting whenever the engine is parked.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + CW'(1);
    end

    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/i2cm_engine.sv
// Bit engine: START, nine-slot byte, parked hold and STOP sequencing.
// Each bus bit is four phases; SCL is high in the middle two.
// Assumes go_* inputs are only raised while idle (start) or parked.
module i2cm_engine #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          go_start,
    input  logic          go_stop,
    input  logic          go_byte,
    input  logic          rx_mode,
    input  logic          ack_gen,
    input  logic [BW-1:0] tx_byte,
    input  logic          sda_i,
    output logic          idle,
    output logic          hold,
    output logic          run,
    output logic          done,
    output logic [BW-1:0] shift_q,
    output logic          ack_q,
    output logic          scl,
    output logic          sda
);
    import i2cm_pkg::*;
    localparam int SW = $clog2(BW + 1);
    localparam logic [SW-1:0] ACK_SLOT = SW'(BW);

    eng_state_t    state;
    logic [1:0]    phase;
    logic [SW-1:0] slot;
    logic          from_hold, samp, rx_lat, ack_lat;

    assign idle = (state == ENG_IDLE);
    assign hold = (state == ENG_HOLD);
    assign run  = (state == ENG_START) || (state == ENG_BIT) || (state == ENG_STOP);
    assign done = (state == ENG_BIT) && tick && (phase == 2'd3) && (slot == ACK_SLOT);

    // Sequence states and phases, shift data and sample the ACK slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE; phase <= 2'd0; slot <= '0; from_hold <= 1'b0;
            samp <= 1'b0; rx_lat <= 1'b0; ack_lat <= 1'b0; shift_q <= '0; ack_q <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: if (go_start) begin
                    state <= ENG_START; phase <= 2'd0; from_hold <= 1'b0;
                end
                ENG_HOLD: begin
                    if (go_start) begin
                        state <= ENG_START; phase <= 2'd0; from_hold <= 1'b1;
                    end else if (go_stop) begin
                        state <= ENG_STOP; phase <= 2'd0;
                    end else if (go_byte) begin
                        state <= ENG_BIT; phase <= 2'd0; slot <= '0;
                        shift_q <= tx_byte; rx_lat <= rx_mode; ack_lat <= ack_gen;
                    end
                end
                ENG_START: if (tick) begin
                    phase <= phase + 2'd1;
                    if (phase == 2'd3) begin
                        state <= ENG_BIT; slot <= '0; shift_q <= tx_byte;
                        rx_lat <= 1'b0; ack_lat <= ack_gen;
                    end
                end
                ENG_BIT: if (tick) begin
                    phase <= phase + 2'd1;
                    if (phase == 2'd1) begin
                        if (slot == ACK_SLOT) ack_q <= sda_i;
                        else                  samp  <= sda_i;
                    end
                    if (phase == 2'd3) begin
                        if (slot == ACK_SLOT) state <= ENG_HOLD;
                        else begin
                            shift_q <= {shift_q[BW-2:0], samp};
                            slot    <= slot + SW'(1);
                        end
                    end
                end
                ENG_STOP: if (tick) begin
                    phase <= phase + 2'd1;
                    if (phase == 2'd3) state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Line levels from state and phase.
    always_comb begin
        scl = 1'b1; sda = 1'b1;
        case (state)
            ENG_HOLD:  begin scl = 1'b0; sda = 1'b0; end
            ENG_START: begin
                scl = (phase == 2'd0) ? !from_hold : (phase != 2'd3);
                sda = (phase < 2'd2);
            end
            ENG_BIT: begin
                scl = phase[0] ^ phase[1];
                if (slot == ACK_SLOT) sda = rx_lat ? !ack_lat : 1'b1;
                else                  sda = rx_lat ? 1'b1 : shift_q[BW-1];
            end
            ENG_STOP:  begin scl = (phase != 2'd0); sda = phase[1]; end
            default:   begin scl = 1'b1; sda = 1'b1; end
        endcase
    end

    a_r6_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_BIT && $past(state) == ENG_BIT && scl && $past(scl)) |-> $stable(sda));
    a_r3_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_START && $past(state) == ENG_START && $fell(sda)) |-> scl);
    a_r10_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_STOP && $past(state) == ENG_STOP && $rose(sda)) |-> scl);
endmodule

// File: rtl/i2cm_regs.sv
// Register file and command latch for the byte-paced I2C master.
// Commands (START/STOP) wait until pending is clear; a parked engine
// with no command runs the next byte as soon as pending is cleared.
module i2cm_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       eng_idle,
    input  logic       eng_hold,
    input  logic       done,
    input  logic [7:0] eng_byte,
    input  logic       ack_bit,
    output logic       go_start,
    output logic       go_stop,
    output logic       go_byte,
    output logic       rx_mode,
    output logic       ack_gen,
    output logic       pre_hi,
    output logic [3:0] div,
    output logic [7:0] tx_byte,
    output logic       irq,
    output logic       pend
);
    import i2cm_pkg::*;

    logic [7:0] ctrl_q, data_q, sadr_q;
    logic [1:0] mode_q;
    logic       en_q, cmd_start, cmd_stop, busy;

    assign pend     = ctrl_q[4];
    assign irq      = ctrl_q[4] & ctrl_q[5];
    assign ack_gen  = ctrl_q[7];
    assign pre_hi   = ctrl_q[6];
    assign div      = ctrl_q[3:0];
    assign rx_mode  = (mode_q == MODE_MRX);
    assign tx_byte  = data_q;
    assign busy     = !eng_idle || cmd_start;
    assign go_start = cmd_start && !pend && (eng_idle || eng_hold);
    assign go_stop  = cmd_stop && !pend && eng_hold;
    assign go_byte  = !cmd_start && !cmd_stop && !pend && eng_hold;

    // Control register: software may only clear pending; the engine sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else begin
            if (wr && addr == RA_CTRL) ctrl_q <= {wdata[7:5], wdata[4] & ctrl_q[4], wdata[3:0]};
            if (done) ctrl_q[4] <= 1'b1;
        end
    end

    // Status fields and START/STOP command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0; en_q <= 1'b0; cmd_start <= 1'b0; cmd_stop <= 1'b0;
        end else begin
            if (go_start) cmd_start <= 1'b0;
            if (go_stop)  cmd_stop  <= 1'b0;
            if (wr && addr == RA_STAT) begin
                mode_q <= wdata[7:6];
                en_q   <= wdata[4];
                if (wdata[7] && wdata[5] && wdata[4]) begin
                    cmd_start <= 1'b1; cmd_stop <= 1'b0;
                end else if (wdata[4] && !wdata[5] && !eng_idle) begin
                    cmd_stop <= 1'b1; cmd_start <= 1'b0;
                end
            end
        end
    end

    // Data register takes the shifted byte at completion; writes only when not shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if (done) data_q <= eng_byte;
        else if (wr && addr == RA_DATA && (eng_idle || eng_hold)) data_q <= wdata;
    end

    // Address register: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n) sadr_q <= '0;
        else if (wr && addr == RA_SADR) sadr_q <= wdata;
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            RA_CTRL: rdata = ctrl_q;
            RA_STAT: rdata = {mode_q, busy, en_q, 3'b000, ack_bit};
            RA_DATA: rdata = data_q;
            default: rdata = sadr_q;
        endcase
    end

    a_r4_pend_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(done));
endmodule

// File: rtl/i2c_byte_master.sv
// Top of the byte-paced I2C master: register file, tick generator, bit engine.
// Assumes SDA is returned on sda_i as the wired-AND of all drivers.
module i2c_byte_master #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       scl_o,
    output logic       sda_o,
    input  logic       sda_i
);
    import i2cm_pkg::*;

    logic             go_start, go_stop, go_byte, rx_mode, ack_gen, pre_hi, pend;
    logic             eng_idle, eng_hold, eng_run, done, ack_bit, tick;
    logic [DIV_W-1:0] div;
    logic [BYTE_W-1:0] tx_byte, eng_byte;

    i2cm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .eng_idle(eng_idle), .eng_hold(eng_hold), .done(done),
        .eng_byte(eng_byte), .ack_bit(ack_bit), .go_start(go_start), .go_stop(go_stop),
        .go_byte(go_byte), .rx_mode(rx_mode), .ack_gen(ack_gen), .pre_hi(pre_hi),
        .div(div), .tx_byte(tx_byte), .irq(irq), .pend(pend)
    );

    i2cm_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(eng_run), .pre_hi(pre_hi), .div(div), .tick(tick)
    );

    i2cm_engine #(.BW(BYTE_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go_start(go_start), .go_stop(go_stop),
        .go_byte(go_byte), .rx_mode(rx_mode), .ack_gen(ack_gen), .tx_byte(tx_byte),
        .sda_i(sda_i), .idle(eng_idle), .hold(eng_hold), .run(eng_run), .done(done),
        .shift_q(eng_byte), .ack_q(ack_bit), .scl(scl_o), .sda(sda_o)
    );

    a_r5_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !scl_o);
endmodule

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic irq, scl_o, sda_o, sda_i, sl_sda;
    int checks = 0, errors = 0;

    assign sda_i = sda_o & sl_sda;
    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_byte_master uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
    );

    // ---------------- slave model ----------------
    logic prev_scl, prev_line, line, sl_rd, addrph, master_ack, nack_cfg, go;
    logic [7:0] shr;
    logic [7:0] rd_data [4];
    logic [7:0] wlog [16];
    int k, ridx, nlog, start_cnt, stop_cnt, cyc, last_rise, period;

    initial begin
        rd_data[0] = 8'h5A; rd_data[1] = 8'hC3; rd_data[2] = 8'hFF; rd_data[3] = 8'hFF;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            sl_sda = 1'b1; prev_scl = 1'b1; prev_line = 1'b1; k = 0; ridx = 0; nlog = 0;
            start_cnt = 0; stop_cnt = 0; cyc = 0; last_rise = 0; period = 0;
            sl_rd = 1'b0; addrph = 1'b0; master_ack = 1'b1; shr = '0;
        end else begin
            line = sda_o & sl_sda;
            if (scl_o && prev_scl && prev_line && !line) begin
                start_cnt++; k = 0; addrph = 1'b1; sl_sda = 1'b1;
            end else if (scl_o && prev_scl && !prev_line && line) begin
                stop_cnt++; k = 0; addrph = 1'b0; sl_sda = 1'b1;
            end else if (scl_o && !prev_scl) begin
                period = cyc - last_rise; last_rise = cyc;
                if (k < 8) shr = {shr[6:0], line};
                else if (k == 8) master_ack = line;
                k++;
                if (k == 8 && (addrph || !sl_rd)) begin
                    if (nlog < 16) wlog[nlog] = shr;
                    nlog++;
                end
            end else if (!scl_o && prev_scl) begin
                if (k == 8) begin
                    if (addrph || !sl_rd) sl_sda = nack_cfg ? 1'b1 : 1'b0;
                    else sl_sda = 1'b1;
                end else if (k == 9) begin
                    k = 0;
                    if (addrph) begin
                        sl_rd = shr[0]; addrph = 1'b0; go = shr[0]; ridx = 0;
                    end else if (sl_rd) begin
                        ridx++; go = !master_ack;
                    end else go = 1'b0;
                    sl_sda = go ? rd_data[ridx][7] : 1'b1;
                end else if (k >= 1 && k < 8 && sl_rd && !addrph) begin
                    sl_sda = rd_data[ridx][7-k];
                end
            end
            prev_scl = scl_o; prev_line = line; cyc++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_pend();
        logic [7:0] v;
        int n = 0;
        do begin rd(2'd0, v); n++; end while (!v[4] && n < 20000);
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int n = 0;
        do begin rd(2'd1, v); n++; end while (v[5] && n < 20000);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 8'h00, "R1 register reset value", v, 0);
        end
        chk(scl_o && sda_o && !irq, "R1 lines released, irq low", {scl_o, sda_o, irq}, 3'b110);
    endtask

    task automatic t_address_write();
        logic [7:0] v;
        int s0 = start_cnt;
        nack_cfg = 1'b0;
        wr(2'd0, 8'hA2);
        wr(2'd2, 8'hA0);
        wr(2'd1, 8'hF0);
        rd(2'd1, v);
        chk(v[5] == 1'b1, "R3 busy after START write", v[5], 1);
        wait_pend();
        chk(start_cnt == s0 + 1, "R3 START seen by slave", start_cnt, s0 + 1);
        chk(nlog == 1 && wlog[0] == 8'hA0, "R3 address byte", wlog[0], 8'hA0);
        rd(2'd1, v);
        chk(v[0] == 1'b0, "R7 ACK from slave on address", v[0], 0);
        chk(period == 48, "R2 SCL period fast prescale div 2", period, 48);
        chk(irq == 1'b1, "R4 irq with pending and enable", irq, 1);
    endtask

    task automatic t_stretch();
        logic [7:0] v;
        int bad = 0;
        int n0 = nlog;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (scl_o) bad++;
        end
        chk(bad == 0, "R5 SCL held low while pending", bad, 0);
        rd(2'd0, v);
        chk(v[4] == 1'b1 && nlog == n0, "R5 no byte while pending", nlog, n0);
    endtask

    task automatic t_write_byte(input logic [7:0] b, input logic nack);
        logic [7:0] v;
        int n0 = nlog;
        nack_cfg = nack;
        wr(2'd2, b);
        wr(2'd0, 8'hA2);
        rd(2'd0, v);
        chk(v[4] == 1'b0, "R4 software clears pending", v[4], 0);
        wait_pend();
        chk(nlog == n0 + 1 && wlog[n0] == b, "R6 transmitted byte", wlog[n0], b);
        rd(2'd1, v);
        chk(v[0] == nack, "R7 received ACK bit", v[0], nack);
        nack_cfg = 1'b0;
    endtask

    task automatic t_rstart_read();
        logic [7:0] v;
        int s0 = start_cnt;
        int p0 = stop_cnt;
        int n0 = nlog;
        wr(2'd2, 8'hA1);
        wr(2'd1, 8'hB0);
        wr(2'd0, 8'hA2);
        wait_pend();
        chk(start_cnt == s0 + 1 && stop_cnt == p0, "R9 repeated START without STOP",
            stop_cnt, p0);
        chk(wlog[n0] == 8'hA1, "R9 read address byte", wlog[n0], 8'hA1);
        wr(2'd0, 8'hA2);
        wait_pend();
        rd(2'd2, v);
        chk(v == 8'h5A, "R8 first received byte", v, 8'h5A);
        chk(master_ack == 1'b0, "R8 master ACK with ACK enable", master_ack, 0);
        wr(2'd0, 8'h22);
        wait_pend();
        rd(2'd2, v);
        chk(v == 8'hC3, "R8 last received byte", v, 8'hC3);
        chk(master_ack == 1'b1, "R8 master NACK with ACK enable clear", master_ack, 1);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        int p0 = stop_cnt;
        wr(2'd1, 8'h90);
        wr(2'd0, 8'h22);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(stop_cnt == p0 + 1, "R10 STOP seen by slave", stop_cnt, p0 + 1);
        rd(2'd1, v);
        chk(v[5] == 1'b0, "R10 busy clear after STOP", v[5], 0);
        rd(2'd0, v);
        chk(v[4] == 1'b0, "R10 pending stays clear", v[4], 0);
        chk(scl_o && sda_o, "R10 lines released", {scl_o, sda_o}, 2'b11);
    endtask

    task automatic t_slow_prescale();
        wr(2'd0, 8'hE0);
        wr(2'd2, 8'hA0);
        wr(2'd1, 8'hF0);
        wait_pend();
        chk(period == 512, "R2 SCL period slow prescale div 0", period, 512);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'h00);
        wait_idle();
    endtask

    task automatic t_sw_set_pend();
        logic [7:0] v;
        wr(2'd0, 8'h30);
        rd(2'd0, v);
        chk(v == 8'h20, "R4 writing 1 does not set pending", v, 8'h20);
        chk(irq == 1'b0 && scl_o, "R4 no irq or activity from write", irq, 0);
    endtask

    task automatic t_addr_reg();
        logic [7:0] v;
        wr(2'd3, 8'h5B);
        rd(2'd3, v);
        chk(v == 8'h5B, "R11 address register storage", v, 8'h5B);
    endtask

    initial begin
        nack_cfg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_address_write();
        t_stretch();
        t_write_byte(8'h3C, 1'b0);
        t_write_byte(8'h81, 1'b1);
        t_rstart_read();
        t_stop();
        t_slow_prescale();
        t_sw_set_pend();
        t_addr_reg();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule